// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit sits between instruction decode and execution in a small accumulator processor. It takes an 18-bit instruction word and produces the operand location, or the operand itself, according to the word's two-bit addressing mode. It owns two 13-bit index registers. An indirect operand takes an extra memory read, which goes through a registered address output and a request/ready handshake.

An accepted instruction finishes with a one-cycle `done` pulse. With that pulse come the 13-bit result, a flag that marks the result as an immediate value, and the instruction's opcode, so the execute stage gets everything it needs in one beat. Any start that arrives while an indirect read is still pending is dropped.

Top module: `eaddr_gen`

## Requirements
- R1: The instruction word packs the opcode in bits 17:15, the mode in bits 14:13 and the address field in bits 12:0. The opcode of the accepted instruction appears on `op_out` while `done` is high.
- R2: Mode 00 (direct) raises `done` in the cycle after the start is accepted, with `ea` equal to the address field and `is_imm` low. It makes no memory request.
- R3: Mode 11 (immediate) raises `done` in the cycle after acceptance, with `ea` equal to the address field and `is_imm` high. It makes no memory request.
- R4: Mode 10 (indexed) raises `done` in the cycle after acceptance. `ea` is the address field plus an index register, taken modulo 2^13. Opcode bit 15 selects the index register: 0 selects A, 1 selects B.
- R5: `ld_ia` or `ld_ib` writes `idx_din` into index register A or B at the clock edge. An indexed start sampled at that same edge uses the value the register held before the write.
- R6: Mode 01 (indirect) raises `mem_req` in the cycle after acceptance, with `mem_addr` equal to the address field. Both stay unchanged until `mem_ready` is sampled high.
- R7: When `mem_req` and `mem_ready` are both high at an edge, the next cycle shows `done` high, `ea` equal to the `mem_rdata` of that edge, `is_imm` low, and `mem_req` low.
- R8: `busy` is high from the cycle after an indirect start until completion. A start seen while `busy` is high is ignored: it produces no `done` and does not disturb `mem_addr` or the pending read.
- R9: After reset, `done`, `busy`, `mem_req`, `is_imm` and `ea` are zero, and both index registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 18 | Instruction word: opcode, mode, address field |
| ld_ia | input | 1 | Write `idx_din` into index register A |
| ld_ib | input | 1 | Write `idx_din` into index register B |
| idx_din | input | 13 | Index register write data |
| mem_req | output | 1 | Memory read request for an indirect pointer |
| mem_addr | output | 13 | Registered memory address |
| mem_ready | input | 1 | Memory has the read word on `mem_rdata` |
| mem_rdata | input | 13 | Pointer bits of the memory word |
| busy | output | 1 | Indirect read in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 13 | Effective address or immediate value |
| is_imm | output | 1 | `ea` holds an immediate operand |
| op_out | output | 3 | Opcode of the completed instruction |

## Verification
The bench aims index sums past 2^13 through both registers. A design that drops the wrap or swaps the register choice would then return a 14-bit-truncated or foreign sum. It loads an index register on the very edge an indexed start is taken, which exposes a design that forwards the new value. During a long indirect wait it sends a second start. A design without busy gating would then pulse `done` early or overwrite the pointer address. It also checks that immediate and direct modes never raise `mem_req`, since a design that issues stray reads there would be caught.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [1:0] {
      AM_DIRECT   = 2'b00,
      AM_INDIRECT = 2'b01,
      AM_INDEXED  = 2'b10,
      AM_IMMED    = 2'b11
   } amode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } eag_state_e;
endpackage

// File: rtl/eag_index_bank.sv
module eag_index_bank #(
   parameter int AW  = 13,
   parameter int NUM = 2,
   localparam int SW = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] wr_en,
   input  logic [AW-1:0]  wdata,
   input  logic [SW-1:0]  sel,
   output logic [AW-1:0]  rdata
);
   logic [AW-1:0] regs [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en[g])
            regs[g] <= wdata;
      end
   end

   assign rdata = regs[sel];
endmodule

// File: rtl/eag_mem_port.sv
module eag_mem_port #(
   parameter int AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] ptr,
   input  logic          ready,
   input  logic [AW-1:0] rdata,
   output logic          req,
   output logic [AW-1:0] mar,
   output logic          fill,
   output logic [AW-1:0] fill_word
);
   logic          req_q;
   logic [AW-1:0] mar_q;

   assign fill      = req_q & ready;
   assign fill_word = rdata;
   assign req       = req_q;
   assign mar       = mar_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         mar_q <= '0;
      end else if (launch) begin
         req_q <= 1'b1;
         mar_q <= ptr;
      end else if (fill) begin
         req_q <= 1'b0;
      end
   end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
   import eag_pkg::*;
#(
   parameter int OPC_W  = 3,
   parameter int MODE_W = 2,
   parameter int ADDR_W = 13,
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] instr,
   input  logic              ld_ia,
   input  logic              ld_ib,
   input  logic [ADDR_W-1:0] idx_din,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] ea,
   output logic              is_imm,
   output logic [OPC_W-1:0]  op_out
);
   localparam int NUM_IDX  = 2;
   localparam int SEL_W    = $clog2(NUM_IDX);
   localparam int FLD_LO   = 0;
   localparam int MODE_LO  = FLD_LO + ADDR_W;
   localparam int OPC_LO   = MODE_LO + MODE_W;

   if (OPC_W + MODE_W + ADDR_W != WORD_W) begin : g_bad_word
      $error("eaddr_gen: field widths do not sum to WORD_W");
   end
   if (MODE_W != 2) begin : g_bad_mode
      $error("eaddr_gen: four modes need MODE_W of 2");
   end
   if (SEL_W > OPC_W) begin : g_bad_sel
      $error("eaddr_gen: index select wider than opcode");
   end

   logic [OPC_W-1:0]  opc;
   amode_e            mode;
   logic [ADDR_W-1:0] field;
   logic [ADDR_W-1:0] idx_val;
   logic [ADDR_W-1:0] idx_sum;
   eag_state_e        state_q;
   logic              accept;
   logic              launch;
   logic              fill;
   logic [ADDR_W-1:0] fill_word;
   logic              done_q;
   logic              imm_q;
   logic [ADDR_W-1:0] res_q;
   logic [OPC_W-1:0]  op_q;

   assign opc     = instr[OPC_LO +: OPC_W];
   assign mode    = amode_e'(instr[MODE_LO +: MODE_W]);
   assign field   = instr[FLD_LO +: ADDR_W];
   assign accept  = start && (state_q == ST_IDLE);
   assign launch  = accept && (mode == AM_INDIRECT);
   assign idx_sum = field + idx_val;

   eag_index_bank #(.AW(ADDR_W), .NUM(NUM_IDX)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en ({ld_ib, ld_ia}),
      .wdata (idx_din),
      .sel   (opc[SEL_W-1:0]),
      .rdata (idx_val)
   );

   eag_mem_port #(.AW(ADDR_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .ptr       (field),
      .ready     (mem_ready),
      .rdata     (mem_rdata),
      .req       (mem_req),
      .mar       (mem_addr),
      .fill      (fill),
      .fill_word (fill_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         imm_q   <= 1'b0;
         res_q   <= '0;
         op_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_q  <= opc;
            imm_q <= 1'b0;
            unique case (mode)
               AM_DIRECT: begin
                  res_q  <= field;
                  done_q <= 1'b1;
               end
               AM_INDEXED: begin
                  res_q  <= idx_sum;
                  done_q <= 1'b1;
               end
               AM_IMMED: begin
                  res_q  <= field;
                  imm_q  <= 1'b1;
                  done_q <= 1'b1;
               end
               AM_INDIRECT: begin
                  state_q <= ST_WAIT;
               end
               default: ;
            endcase
         end else if (state_q == ST_WAIT && fill) begin
            res_q   <= fill_word;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
         end
      end
   end

   assign busy   = (state_q == ST_WAIT);
   assign done   = done_q;
   assign ea     = res_q;
   assign is_imm = imm_q;
   assign op_out = op_q;
endmodule

// File: rtl/eaddr_gen_chk.sv
module eaddr_gen_chk #(
   parameter int OPC_W  = 3,
   parameter int ADDR_W = 13,
   parameter int WORD_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [WORD_W-1:0] instr,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_rdata,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] ea,
   input logic              is_imm,
   input logic [OPC_W-1:0]  op_out
);
   logic [1:0] m;
   logic       take;
   assign m    = instr[ADDR_W +: 2];
   assign take = start && !busy;

   // R1
   op_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && m != 2'b01 |=> done && op_out == $past(instr[WORD_W-1 -: OPC_W]));

   // R2
   direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && m == 2'b00 |=> done && !is_imm && !mem_req && ea == $past(instr[ADDR_W-1:0]));

   // R3
   immed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && m == 2'b11 |=> done && is_imm && !mem_req && ea == $past(instr[ADDR_W-1:0]));

   // R6
   ind_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && m == 2'b01 |=> mem_req && busy && !done && mem_addr == $past(instr[ADDR_W-1:0]));

   // R6
   ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

   // R7
   ind_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> done && !busy && !mem_req && !is_imm && ea == $past(mem_rdata));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ready |=> !done && busy);

   // R9
   reset_chk: assert property (@(posedge clk)
      !rst_n |=> !done && !busy && !mem_req && ea == '0);
endmodule

bind eaddr_gen eaddr_gen_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .instr     (instr),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ready (mem_ready),
   .mem_rdata (mem_rdata),
   .busy      (busy),
   .done      (done),
   .ea        (ea),
   .is_imm    (is_imm),
   .op_out    (op_out)
);

// File: tb/tb_eaddr_gen.sv
module tb_eaddr_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [17:0] instr;
   logic        ld_ia, ld_ib;
   logic [12:0] idx_din;
   logic        mem_req;
   logic [12:0] mem_addr;
   logic        mem_ready;
   logic [12:0] mem_rdata;
   logic        busy, done, is_imm;
   logic [12:0] ea;
   logic [2:0]  op_out;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   eaddr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .ld_ia(ld_ia), .ld_ib(ld_ib), .idx_din(idx_din),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea),
      .is_imm(is_imm), .op_out(op_out)
   );

   // {instr[17:0], expected ea[12:0], expected is_imm}; IA=0x0100, IB=0x1FF0
   localparam logic [31:0] VEC [6] = '{
      {3'b000, 2'b00, 13'h0ABC, 13'h0ABC, 1'b0},
      {3'b101, 2'b11, 13'h1234, 13'h1234, 1'b1},
      {3'b010, 2'b10, 13'h1F05, 13'h0005, 1'b0},
      {3'b011, 2'b10, 13'h0020, 13'h0010, 1'b0},
      {3'b110, 2'b00, 13'h1FFF, 13'h1FFF, 1'b0},
      {3'b111, 2'b11, 13'h0000, 13'h0000, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [17:0] w);
      @(negedge clk);
      instr = w;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic load_idx(input bit b, input logic [12:0] v);
      @(negedge clk);
      ld_ia = !b;
      ld_ib = b;
      idx_din = v;
      @(negedge clk);
      ld_ia = 1'b0;
      ld_ib = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; instr = '0; ld_ia = 1'b0; ld_ib = 1'b0;
      idx_din = '0; mem_ready = 1'b0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!done && !busy && !mem_req && !is_imm && ea == 0, "R9", {done, busy, mem_req, is_imm}, 0);

      // R9 index registers clear, R5 same-edge load uses old value
      @(negedge clk);
      instr = {3'b000, 2'b10, 13'h0007};
      start = 1'b1;
      ld_ia = 1'b1;
      idx_din = 13'h0100;
      @(negedge clk);
      start = 1'b0;
      ld_ia = 1'b0;
      chk(done && ea == 13'h0007, "R5", ea, 13'h0007);
      issue({3'b000, 2'b10, 13'h0007});
      chk(done && ea == 13'h0107, "R5", ea, 13'h0107);
      load_idx(1'b1, 13'h1FF0);

      // table walk for R1 R2 R3 R4
      for (int i = 0; i < 6; i++) begin
         issue(VEC[i][31:14]);
         chk(done, "R2", done, 1);
         chk(ea == VEC[i][13:1], "R4", ea, VEC[i][13:1]);
         chk(is_imm == VEC[i][0], "R3", is_imm, VEC[i][0]);
         chk(!mem_req, "R2", mem_req, 0);
         chk(op_out == VEC[i][31:29], "R1", op_out, VEC[i][31:29]);
         @(negedge clk);
         chk(!done, "R2", done, 0);
      end

      // R6 R7 R8 indirect with a long wait and an ignored start
      issue({3'b100, 2'b01, 13'h0ACE});
      chk(mem_req && busy && mem_addr == 13'h0ACE, "R6", mem_addr, 13'h0ACE);
      chk(!done, "R6", done, 0);
      for (int k = 0; k < 5; k++) begin
         if (k == 2) begin
            instr = {3'b001, 2'b00, 13'h1111};
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         chk(!done && busy, "R8", {done, busy}, 1);
         chk(mem_req && mem_addr == 13'h0ACE, "R8", mem_addr, 13'h0ACE);
      end
      start = 1'b0;
      mem_ready = 1'b1;
      mem_rdata = 13'h1B2D;
      @(negedge clk);
      mem_ready = 1'b0;
      mem_rdata = '0;
      chk(done && ea == 13'h1B2D && !is_imm, "R7", ea, 13'h1B2D);
      chk(!mem_req && !busy, "R7", {mem_req, busy}, 0);
      chk(op_out == 3'b100, "R1", op_out, 3'b100);
      @(negedge clk);
      chk(!done, "R7", done, 0);

      // R6 ready already high when request appears
      mem_ready = 1'b1;
      mem_rdata = 13'h0042;
      issue({3'b000, 2'b01, 13'h0003});
      chk(mem_req && mem_addr == 13'h0003, "R6", mem_addr, 13'h0003);
      @(negedge clk);
      mem_ready = 1'b0;
      chk(done && ea == 13'h0042, "R7", ea, 13'h0042);

      // R8 start right after completion is accepted again
      issue({3'b011, 2'b11, 13'h0999});
      chk(done && is_imm && ea == 13'h0999, "R8", ea, 13'h0999);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule